// File: doc/BRIEF.md
# Neighbourhood Window Generator

This block turns a raster stream of 8-bit pixels into a square neighbourhood around one centre pixel, for use by a grayscale morphology stage such as a max/min reduction. A chain of six line memories stores the previous image rows. Each accepted pixel and the six stored pixels of the same column shift into a 7×7 register array. The same array serves three window sizes, 3×3, 5×5 and 7×7, by gating which taps are presented. Every size is centred on the same pixel, so the output delay does not depend on the size.

Pixels arrive with a valid strobe, a start-of-frame marker on the first pixel and an optional end-of-line marker. The line width and the window size are configuration inputs that are sampled when a frame starts. For each output window the block gives a per-tap mask that clears taps lying above or left of the image, and a border flag when any selected tap is clipped. The downstream stage can then ignore the clipped taps.

Top module: `nbw_window_gen`

## Requirements
- R1: After reset, win_valid, win_border and every win_tap_ok bit are 0 until a frame is in progress.
- R2: win_pix holds 49 taps. Tap i (bits i*8+7..i*8) is the pixel at row cy+(i/7)-3, column cx+(i%7)-3, where (cy,cx) is the window centre. Accepting the pixel at (row y, column x) produces, in the next cycle, the window centred at (y-3, x-3).
- R3: cfg_size selects the window: 00 gives 3×3, 01 gives 5×5, 10 or 11 gives 7×7, all centred on tap 24. Taps outside the selected size read 0 and have win_tap_ok low.
- R4: win_valid is high exactly in the cycle after an accepted pixel whose row and column are both at least 3. In every other cycle, including idle cycles with pix_valid low, it is low.
- R5: While win_valid is high, win_tap_ok[i] is 1 only when tap i is inside the selected size and its row and column are both at least 0. While win_valid is low, all mask bits are 0.
- R6: win_border is high with win_valid when cy or cx is smaller than the half-size (1, 2 or 3).
- R7: A line ends after cfg_width pixels (1 to MAX_LINE; MAX_LINE is a parameter, up to 1024). The width is sampled on the start-of-frame pixel, so a change during a frame has no effect on that frame.
- R8: cfg_size is sampled on the start-of-frame pixel, so a change during a frame has no effect until the next start of frame.
- R9: pix_eol on an accepted pixel ends its line even before cfg_width pixels have arrived.
- R10: A pixel with pix_sof and pix_valid high is row 0, column 0 and restarts the frame, even in the middle of a line. Valid pixels before the first start of frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | PIX_W | Pixel value |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a line |
| cfg_width | input | $clog2(MAX_LINE)+1 | Line width in pixels |
| cfg_size | input | 2 | Window size select |
| win_valid | output | 1 | Window output valid |
| win_pix | output | 49*PIX_W | Flattened 7×7 window, tap 0 at the top left |
| win_tap_ok | output | 49 | Per-tap in-image and in-size mask |
| win_border | output | 1 | Window clipped by the image edge |

## Verification
Random frames with random idle gaps are sent in every size and at several widths, including a line narrower than the window. Each output is compared against a model image. Taps that land a line too high or low, or a column off, show up as pixel mismatches. Taps that are wrongly gated show up in the zero and mask checks. A frame with mid-frame changes to width and size separates sampling at start of frame from live use. A frame with early end-of-line markers, valid pixels sent before any start of frame, and a restart in the middle of a line check the position counting.

// File: rtl/nbw_pkg.sv
package nbw_pkg;
  localparam int WIN_N    = 7;
  localparam int WIN_TAPS = WIN_N * WIN_N;
  localparam int CTR      = (WIN_N - 1) / 2;

  // half-size of the window for a size-select code
  function automatic logic [1:0] half_of(input logic [1:0] sel);
    case (sel)
      2'b00:   return 2'd1;
      2'b01:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/nbw_linebuf.sv
module nbw_linebuf #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [PIX_W-1:0] din,
  output logic [PIX_W-1:0] dout
);
  logic [PIX_W-1:0] mem [DEPTH];

  // read returns the old entry; write-after-read in one cycle
  assign dout = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= din;
  end
endmodule

// File: rtl/nbw_raster.sv
module nbw_raster
  import nbw_pkg::*;
#(
  parameter int MAX_LINE = 256,
  localparam int CW = $clog2(MAX_LINE),
  localparam int WW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          pix_sof,
  input  logic          pix_eol,
  input  logic [WW-1:0] cfg_width,
  input  logic [1:0]    cfg_size,
  output logic          acc,
  output logic [CW-1:0] wr_col,
  output logic          acc_q,
  output logic [CW-1:0] cur_col_q,
  output logic [2:0]    cur_row_q,
  output logic [1:0]    half_q
);
  logic          in_frame_q, in_frame_d;
  logic [CW-1:0] col_q, col_d, cur_col_d;
  logic [2:0]    row_q, row_d, py, row_inc, cur_row_d;
  logic [WW-1:0] wdt_q, wdt_d, w_eff;
  logic [1:0]    half_d;
  logic          frame_start, line_end;

  always_comb begin
    frame_start = pix_valid & pix_sof;
    acc         = pix_valid & (pix_sof | in_frame_q);
    wr_col      = pix_sof ? '0 : col_q;
    py          = pix_sof ? 3'd0 : row_q;
    w_eff       = pix_sof ? cfg_width : wdt_q;
    line_end    = pix_eol | ({1'b0, wr_col} == (w_eff - {{CW{1'b0}}, 1'b1}));
    row_inc     = (py == 3'd7) ? py : py + 3'd1;

    col_d       = col_q;
    row_d       = row_q;
    cur_col_d   = cur_col_q;
    cur_row_d   = cur_row_q;
    if (acc) begin
      col_d     = line_end ? '0 : wr_col + {{(CW-1){1'b0}}, 1'b1};
      row_d     = line_end ? row_inc : py;
      cur_col_d = wr_col;
      cur_row_d = py;
    end

    in_frame_d = in_frame_q | frame_start;
    wdt_d      = frame_start ? cfg_width : wdt_q;
    half_d     = frame_start ? half_of(cfg_size) : half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      col_q      <= '0;
      row_q      <= '0;
      wdt_q      <= '0;
      half_q     <= 2'd3;
      cur_col_q  <= '0;
      cur_row_q  <= '0;
      acc_q      <= 1'b0;
    end else begin
      in_frame_q <= in_frame_d;
      col_q      <= col_d;
      row_q      <= row_d;
      wdt_q      <= wdt_d;
      half_q     <= half_d;
      cur_col_q  <= cur_col_d;
      cur_row_q  <= cur_row_d;
      acc_q      <= acc;
    end
  end
endmodule

// File: rtl/nbw_taps.sv
module nbw_taps #(
  parameter int PIX_W = 8,
  parameter int N     = 7
) (
  input  logic                      clk,
  input  logic                      en,
  input  logic [N-1:0][PIX_W-1:0]   col_in,
  output logic [N*N-1:0][PIX_W-1:0] raw
);
  // raw[r*N+c] = pixel r rows above and c columns left of the newest pixel
  logic [N*N-1:0][PIX_W-1:0] win_q, win_d;

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      if (c == 0) begin : g_head
        assign win_d[r*N] = col_in[r];
      end else begin : g_body
        assign win_d[r*N+c] = win_q[r*N+c-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en) win_q <= win_d;
  end

  assign raw = win_q;
endmodule

// File: rtl/nbw_window_gen.sv
module nbw_window_gen
  import nbw_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int MAX_LINE = 256,
  localparam int CW = $clog2(MAX_LINE),
  localparam int WW = CW + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pix_valid,
  input  logic [PIX_W-1:0]          pix_data,
  input  logic                      pix_sof,
  input  logic                      pix_eol,
  input  logic [WW-1:0]             cfg_width,
  input  logic [1:0]                cfg_size,
  output logic                      win_valid,
  output logic [WIN_TAPS*PIX_W-1:0] win_pix,
  output logic [WIN_TAPS-1:0]       win_tap_ok,
  output logic                      win_border
);
  logic                                acc, acc_q;
  logic [CW-1:0]                       wr_col, cur_col_q;
  logic [2:0]                          cur_row_q;
  logic [1:0]                          size_half;
  logic [WIN_N-1:0][PIX_W-1:0]         col_vec;
  logic [WIN_N-2:0][PIX_W-1:0]         lb_out;
  logic [WIN_TAPS-1:0][PIX_W-1:0]      raw;

  nbw_raster #(.MAX_LINE(MAX_LINE)) u_ras (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_sof   (pix_sof),
    .pix_eol   (pix_eol),
    .cfg_width (cfg_width),
    .cfg_size  (cfg_size),
    .acc       (acc),
    .wr_col    (wr_col),
    .acc_q     (acc_q),
    .cur_col_q (cur_col_q),
    .cur_row_q (cur_row_q),
    .half_q    (size_half)
  );

  assign col_vec[0] = pix_data;

  for (genvar k = 0; k < WIN_N - 1; k++) begin : g_lb
    logic [PIX_W-1:0] lb_in;
    if (k == 0) begin : g_first
      assign lb_in = pix_data;
    end else begin : g_next
      assign lb_in = lb_out[k-1];
    end
    nbw_linebuf #(.PIX_W(PIX_W), .DEPTH(MAX_LINE)) u_lb (
      .clk  (clk),
      .we   (acc),
      .addr (wr_col),
      .din  (lb_in),
      .dout (lb_out[k])
    );
    assign col_vec[k+1] = lb_out[k];
  end

  nbw_taps #(.PIX_W(PIX_W), .N(WIN_N)) u_taps (
    .clk    (clk),
    .en     (acc),
    .col_in (col_vec),
    .raw    (raw)
  );

  always_comb begin
    win_valid  = acc_q && (cur_row_q >= 3'(CTR)) && (int'(cur_col_q) >= CTR);
    win_border = win_valid &&
                 ((int'(cur_row_q) < CTR + int'(size_half)) ||
                  (int'(cur_col_q) < CTR + int'(size_half)));
  end

  // output tap i sits at row offset i/7-3, column offset i%7-3 from the centre
  for (genvar i = 0; i < WIN_TAPS; i++) begin : g_out
    localparam int RI = i / WIN_N;
    localparam int CI = i % WIN_N;
    logic in_size, in_img;
    always_comb begin
      in_size = (RI + int'(size_half) >= CTR) && (RI <= CTR + int'(size_half)) &&
                (CI + int'(size_half) >= CTR) && (CI <= CTR + int'(size_half));
      in_img  = (int'(cur_row_q) + RI >= 2*CTR) && (int'(cur_col_q) + CI >= 2*CTR);
      win_pix[i*PIX_W +: PIX_W] = in_size ? raw[WIN_TAPS-1-i] : '0;
      win_tap_ok[i]             = win_valid && in_size && in_img;
    end
  end
endmodule

// File: rtl/nbw_chk.sv
module nbw_chk #(
  parameter int PIX_W = 8,
  parameter int TAPS  = 49
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pix_valid,
  input logic                  pix_sof,
  input logic                  win_valid,
  input logic                  win_border,
  input logic [TAPS*PIX_W-1:0] win_pix,
  input logic [TAPS-1:0]       win_tap_ok,
  input logic [1:0]            size_half
);
  // R4
  valid_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> $past(pix_valid));

  // R6
  border_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_border |-> win_valid);

  // R5
  centre_tap_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> win_tap_ok[(TAPS-1)/2]);

  // R5
  idle_mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (win_tap_ok == '0));

  // R3
  corner_zero_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && size_half != 2'd3) |-> (win_pix[PIX_W-1:0] == '0 && !win_tap_ok[0]));

  // R10
  sof_no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_sof) |=> !win_valid);
endmodule

bind nbw_window_gen nbw_chk #(.PIX_W(PIX_W), .TAPS(nbw_pkg::WIN_TAPS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_valid  (pix_valid),
  .pix_sof    (pix_sof),
  .win_valid  (win_valid),
  .win_border (win_border),
  .win_pix    (win_pix),
  .win_tap_ok (win_tap_ok),
  .size_half  (size_half)
);

// File: tb/sim_nbw_window_gen.sv
module sim_nbw_window_gen;
  localparam int PIX_W = 8;
  localparam int MAXL  = 256;
  localparam int WW    = $clog2(MAXL) + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pix_valid = 1'b0;
  logic [PIX_W-1:0]  pix_data = '0;
  logic              pix_sof = 1'b0;
  logic              pix_eol = 1'b0;
  logic [WW-1:0]     cfg_width = '0;
  logic [1:0]        cfg_size = '0;
  logic              win_valid;
  logic [49*PIX_W-1:0] win_pix;
  logic [48:0]       win_tap_ok;
  logic              win_border;

  always #2 clk = ~clk;

  nbw_window_gen #(.PIX_W(PIX_W), .MAX_LINE(MAXL)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_sof(pix_sof), .pix_eol(pix_eol), .cfg_width(cfg_width),
    .cfg_size(cfg_size), .win_valid(win_valid), .win_pix(win_pix),
    .win_tap_ok(win_tap_ok), .win_border(win_border)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;
  string tag = "";

  logic [7:0] img [16][16];
  int  my = 0, mx = 0, mw = 0, mh = 3;
  bit  in_fr = 0;

  function automatic int half_f(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 3;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag, act, exp);
    end
  endtask

  // one clock beat; outputs checked 1 ns after the edge
  task automatic push(input bit vld, input logic [7:0] d, input bit sof, input bit eol);
    bit acc, ev, pbad, zbad, mbad, eb;
    int px, py, cy, cx, bad_i, bad_a, bad_e;
    @(negedge clk);
    pix_valid = vld; pix_data = d; pix_sof = sof; pix_eol = eol;
    acc = vld && (sof || in_fr);
    ev = 0; px = 0; py = 0;
    if (vld && sof) begin
      in_fr = 1; mw = int'(cfg_width); mh = half_f(cfg_size);
    end
    if (acc) begin
      px = sof ? 0 : mx; py = sof ? 0 : my;
      if (py < 16 && px < 16) img[py][px] = d;
      ev = (py >= 3) && (px >= 3);
      if (eol || px == mw - 1) begin mx = 0; my = py + 1; end
      else begin mx = px + 1; my = py; end
    end
    @(posedge clk);
    #1;
    chk(win_valid == ev, "R4 valid", longint'(win_valid), longint'(ev));
    if (ev && win_valid) begin
      cy = py - 3; cx = px - 3;
      pbad = 0; zbad = 0; mbad = 0; bad_i = 0; bad_a = 0; bad_e = 0;
      for (int i = 0; i < 49; i++) begin
        int dr, dc, a;
        bit insz, inimg;
        dr = i / 7 - 3; dc = i % 7 - 3;
        insz  = (dr >= -mh) && (dr <= mh) && (dc >= -mh) && (dc <= mh);
        inimg = (cy + dr >= 0) && (cx + dc >= 0);
        a = int'(win_pix[i*8 +: 8]);
        if (insz && inimg && a != int'(img[cy+dr][cx+dc]) && !pbad) begin
          pbad = 1; bad_i = i; bad_a = a; bad_e = int'(img[cy+dr][cx+dc]);
        end
        if (!insz && a != 0) zbad = 1;
        if (win_tap_ok[i] != (insz && inimg)) mbad = 1;
      end
      if (pbad) $display("  tap %0d mismatch", bad_i);
      chk(!pbad, "R2 tap pixel", longint'(bad_a), longint'(bad_e));
      chk(!zbad, "R3 outside-size zero", longint'(zbad), 0);
      chk(!mbad, "R5 tap mask", longint'(win_tap_ok), -1);
      eb = (cy < mh) || (cx < mh);
      chk(win_border == eb, "R6 border", longint'(win_border), longint'(eb));
    end
    pix_valid = 0; pix_sof = 0; pix_eol = 0;
  endtask

  // width/size set before the frame; mid=1 changes both after the first row
  task automatic run_frame(input int w, input int rows, input logic [1:0] sz,
                           input int eolpos, input int lim, input bit mid);
    int cnt = 0;
    int len;
    cfg_width = WW'(w); cfg_size = sz;
    len = (eolpos > 0) ? eolpos : w;
    for (int y = 0; y < rows; y++) begin
      if (mid && y == 1) begin cfg_width = WW'(w - 2); cfg_size = ~sz; end
      for (int x = 0; x < len; x++) begin
        if (lim > 0 && cnt >= lim) return;
        if (($urandom % 5) == 0) push(0, 8'h00, 0, 0);
        push(1, 8'($urandom), (y == 0 && x == 0), (eolpos > 0) && (x == len - 1));
        cnt++;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    tag = "reset";
    chk(win_valid == 0, "R1 valid", longint'(win_valid), 0);
    chk(win_border == 0, "R1 border", longint'(win_border), 0);
    chk(win_tap_ok == '0, "R1 mask", longint'(win_tap_ok), 0);
    @(negedge clk); rst_n = 1;

    tag = "R10 pre-frame pixels";
    for (int k = 0; k < 12; k++) push(1, 8'($urandom), 0, 0);

    tag = "R2 7x7";         run_frame(10, 8, 2'b10, 0, 0, 0);
    tag = "R3 3x3";         run_frame(9, 7, 2'b00, 0, 0, 0);
    tag = "R3 5x5";         run_frame(11, 8, 2'b01, 0, 0, 0);
    tag = "R7 R8 mid-frame change"; run_frame(9, 8, 2'b00, 0, 0, 1);
    tag = "R9 eol";         run_frame(12, 7, 2'b01, 8, 0, 0);
    tag = "R7 narrow";      run_frame(4, 8, 2'b11, 0, 0, 0);
    tag = "R10 restart";    run_frame(8, 6, 2'b10, 0, 37, 0);
    tag = "R10 after restart"; run_frame(7, 9, 2'b01, 0, 0, 0);
    tag = "R4 idle";
    for (int k = 0; k < 4; k++) push(0, 8'hff, 0, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule